// File: doc/BRIEF.md
# Compare Match Timer Channel

This block is one timer channel. A 16-bit up-counter advances on a tick taken from a prescaler. A two-bit clock-select field picks the prescale ratio. The counter is compared with a 16-bit compare register. When the two are equal, a sticky match flag in the control/status word is set, and the counter returns to zero on its next tick. If the interrupt enable bit is set, the flag drives the interrupt output.

Software reaches the counter, the compare register and the control/status word over a simple synchronous register bus. The control/status word is at address 0, the counter at address 1 and the compare register at address 2; address 3 reads as zero. Read data appears on `rd_data_o` one clock after `rd_en_i`. Clearing the flag takes two steps. Software first reads the control/status word while the flag is 1, which arms the clear. The next write to that word then clears the flag only if it carries a 0 in bit 7. The `start_i` input gates the counting.

Top module: `cmt_channel`

## Requirements
- R1: After reset the control/status word reads 0x0000, the counter reads 0x0000, the compare register reads 0xFFFF and `irq_o` is low.
- R2: In the control/status word, bit 7 is the match flag, bit 6 the interrupt enable and bits 1:0 the clock select. Bits 15:8 and 5:2 always read 0 and ignore writes. Address 3 reads 0. Read data is valid one cycle after the read strobe.
- R3: While `start_i` is high, the counter advances once every 8, 32, 128 or 512 clocks for clock-select values 00, 01, 10 and 11 respectively.
- R4: While `start_i` is low, the counter and the prescaler hold their values.
- R5: In every cycle in which the counter equals the compare register, the match flag is set on the following edge.
- R6: A tick that arrives while the counter equals the compare register loads the counter with 0x0000.
- R7: Writing 1 to bit 7 never changes the flag. Writing 0 to bit 7 without a prior armed read does not clear it.
- R8: A read of the control/status word while the flag is 1 arms a clear. The next write to that word consumes the arming. That write clears the flag if its bit 7 is 0.
- R9: When a match and a qualified clear occur in the same cycle, the flag stays set.
- R10: `irq_o` is high exactly when both the match flag and the interrupt enable are 1.
- R11: A write to the counter or to the compare register takes effect on the next edge. A counter write has priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Count enable |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 16 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 16 | Registered read data |
| irq_o | output | 1 | Compare match interrupt |

## Verification
The assertions assume that the bus carries at most one access per cycle, and that the read and write strobes are never raised together. The arming rule is only well defined when a read and a write are separate events. The bench drives each access in its own cycle and leaves a gap before every read that follows a write. Every count window is a whole multiple of the selected prescale ratio, so any window of that length holds exactly one tick per ratio, whatever the prescaler phase.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;
    localparam int SEL_W  = 2;

    localparam logic [ADDR_W-1:0] ADDR_CSR = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CNT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CMP = 2'd2;

    localparam int FLAG_BIT = 7;
    localparam int IE_BIT   = 6;

    typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
    parameter int SEL_W     = 2,
    parameter int BASE_LOG2 = 3,
    parameter int STEP_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int MAX_SEL = (2 ** SEL_W) - 1;
    localparam int PRE_W   = BASE_LOG2 + STEP_LOG2 * MAX_SEL;
    localparam logic [PRE_W-1:0] ALL_ONES = '1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t state_d, state_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        state_d = state_q;
        mask    = ALL_ONES >> (STEP_LOG2 * (MAX_SEL - int'(sel_i)));
        tick_o  = run_i && ((state_q.pre & mask) == mask);
        if (run_i) begin
            state_d.pre = state_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // R4
    pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(state_q.pre));
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter
    import cmt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick_i,
    input  logic  wr_cnt_i,
    input  logic  wr_cmp_i,
    input  word_t wdata_i,
    output word_t cnt_o,
    output word_t cmp_o,
    output logic  match_o
);
    typedef struct packed {
        word_t cnt;
        word_t cmp;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        match_o = (state_q.cnt == state_q.cmp);
        if (wr_cmp_i) begin
            state_d.cmp = wdata_i;
        end
        if (wr_cnt_i) begin
            state_d.cnt = wdata_i;
        end else if (tick_i) begin
            state_d.cnt = match_o ? '0 : state_q.cnt + 1'b1;
        end
        cnt_o = state_q.cnt;
        cmp_o = state_q.cmp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.cnt <= '0;
            state_q.cmp <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    // R6
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_cnt_i && match_o) |=> (cnt_o == '0));

    // R11
    cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_i |=> (cnt_o == $past(wdata_i)));

    // R11
    cmp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmp_i |=> (cmp_o == $past(wdata_i)));
endmodule

// File: rtl/cmt_csr.sv
module cmt_csr
    import cmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             match_i,
    input  logic             csr_wr_i,
    input  logic             csr_rd_i,
    input  logic             wflag_i,
    input  logic             wie_i,
    input  logic [SEL_W-1:0] wsel_i,
    output logic             flag_o,
    output logic             ie_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             irq_o
);
    typedef struct packed {
        logic             flag;
        logic             ie;
        logic [SEL_W-1:0] sel;
        logic             armed;
    } csr_state_t;

    csr_state_t state_d, state_q;
    logic       clr;

    always_comb begin
        state_d = state_q;
        clr     = 1'b0;
        if (csr_wr_i) begin
            state_d.ie    = wie_i;
            state_d.sel   = wsel_i;
            state_d.armed = 1'b0;
            clr           = state_q.armed && !wflag_i;
        end else if (csr_rd_i && state_q.flag) begin
            state_d.armed = 1'b1;
        end
        state_d.flag = match_i | (state_q.flag & ~clr);
        flag_o = state_q.flag;
        ie_o   = state_q.ie;
        sel_o  = state_q.sel;
        irq_o  = state_q.flag & state_q.ie;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // R5
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q.flag) |-> $past(match_i));

    // R9
    match_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_i |=> state_q.flag);

    // R8
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state_q.flag) |-> $past(csr_wr_i && state_q.armed && !wflag_i));

    // R7
    no_unarmed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.flag && csr_wr_i && !state_q.armed) |=> state_q.flag);
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    typedef struct packed {
        word_t rdata;
    } bus_state_t;

    bus_state_t bus_d, bus_q;

    logic             tick;
    logic             match;
    logic             csr_wr, csr_rd, cnt_wr, cmp_wr;
    logic             flag, ie;
    logic [SEL_W-1:0] sel;
    word_t            cnt, cmp;

    always_comb begin
        csr_wr = wr_en_i && (addr_i == ADDR_CSR);
        cnt_wr = wr_en_i && (addr_i == ADDR_CNT);
        cmp_wr = wr_en_i && (addr_i == ADDR_CMP);
        csr_rd = rd_en_i && (addr_i == ADDR_CSR);
    end

    cmt_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (start_i),
        .sel_i  (sel),
        .tick_o (tick)
    );

    cmt_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .wr_cnt_i (cnt_wr),
        .wr_cmp_i (cmp_wr),
        .wdata_i  (wr_data_i),
        .cnt_o    (cnt),
        .cmp_o    (cmp),
        .match_o  (match)
    );

    cmt_csr u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .match_i  (match),
        .csr_wr_i (csr_wr),
        .csr_rd_i (csr_rd),
        .wflag_i  (wr_data_i[FLAG_BIT]),
        .wie_i    (wr_data_i[IE_BIT]),
        .wsel_i   (wr_data_i[SEL_W-1:0]),
        .flag_o   (flag),
        .ie_o     (ie),
        .sel_o    (sel),
        .irq_o    (irq_o)
    );

    always_comb begin
        bus_d = bus_q;
        if (rd_en_i) begin
            unique case (addr_i)
                ADDR_CSR: bus_d.rdata = {8'h00, flag, ie, 4'h0, sel};
                ADDR_CNT: bus_d.rdata = cnt;
                ADDR_CMP: bus_d.rdata = cmp;
                default:  bus_d.rdata = '0;
            endcase
        end
        rd_data_o = bus_q.rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q <= '0;
        end else begin
            bus_q <= bus_d;
        end
    end

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == ADDR_CSR) |=> (rd_data_o[15:8] == 8'h00 && rd_data_o[5:2] == 4'h0));

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !cnt_wr) |=> $stable(cnt));

    // R10
    irq_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !ie) |=> !irq_o);
endmodule

// File: tb/cmt_channel_tb.sv
`timescale 1ns/1ps
module cmt_channel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    cmt_channel dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .addr_i    (addr),
        .wr_en_i   (wr_en),
        .wr_data_i (wdata),
        .rd_en_i   (rd_en),
        .rd_data_o (rdata),
        .irq_o     (irq)
    );

    // Monitor: a read strobe seen at an edge yields data just after it.
    always @(posedge clk) begin
        automatic logic seen = rd_en && rst_n;
        #1;
        if (seen) begin
            automatic item_t it = sb_q.pop_front();
            checks++;
            if (rdata !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.tag, rdata, it.exp);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [15:0] e, input string tag);
        item_t it;
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic run(input int n);
        @(negedge clk);
        start = 1'b1;
        repeat (n) @(negedge clk);
        start = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        idle(2);
        rst_n = 1'b1;
        // R1 reset values
        chk_irq(1'b0, "R1 irq");
        rd(2'd0, 16'h0000, "R1 csr");
        rd(2'd1, 16'h0000, "R1 cnt");
        rd(2'd2, 16'hFFFF, "R1 cmp");
        // R2 reserved bits ignored, R7 writing 1 to flag no effect
        wr(2'd0, 16'hFFFF);
        rd(2'd0, 16'h0043, "R2 R7 csr after all-ones write");
        rd(2'd3, 16'h0000, "R2 unmapped address");
        wr(2'd0, 16'h0000);
        // R11 register writes
        wr(2'd2, 16'h0005);
        wr(2'd1, 16'h0000);
        rd(2'd2, 16'h0005, "R11 cmp write");
        // R3 divide by 8
        run(24);
        rd(2'd1, 16'h0003, "R3 div8 count");
        // R4 hold while start low
        idle(20);
        rd(2'd1, 16'h0003, "R4 hold");
        // R3 divide by 32
        wr(2'd0, 16'h0001);
        run(32);
        rd(2'd1, 16'h0004, "R3 div32 count");
        // R5 match, R6 wrap, R10 irq disabled
        wr(2'd0, 16'h0000);
        run(16);
        rd(2'd1, 16'h0000, "R6 wrap after match");
        chk_irq(1'b0, "R10 disabled");
        // R7 write 0 without armed read keeps flag
        wr(2'd0, 16'h0000);
        rd(2'd0, 16'h0080, "R5 R7 flag kept");
        // R8 armed clear, enable interrupt
        wr(2'd0, 16'h0040);
        rd(2'd0, 16'h0040, "R8 cleared");
        chk_irq(1'b0, "R10 no flag");
        // R10 interrupt raised
        wr(2'd1, 16'h0004);
        run(16);
        chk_irq(1'b1, "R10 raised");
        rd(2'd0, 16'h00C0, "R5 flag with ie");
        wr(2'd0, 16'h00C0);
        wr(2'd0, 16'h0040);
        chk_irq(1'b1, "R8 arming consumed");
        rd(2'd0, 16'h00C0, "R8 flag still set");
        wr(2'd0, 16'h0000);
        chk_irq(1'b0, "R10 cleared");
        rd(2'd0, 16'h0000, "R8 cleared again");
        // R9 match coincides with clear
        wr(2'd2, 16'h0000);
        idle(1);
        rd(2'd0, 16'h0080, "R9 standing match");
        wr(2'd0, 16'h0000);
        rd(2'd0, 16'h0080, "R9 flag survives");
        wr(2'd2, 16'hFFFF);
        idle(1);
        rd(2'd0, 16'h0080, "R9 arm");
        wr(2'd0, 16'h0000);
        rd(2'd0, 16'h0000, "R9 clear after match ends");
        idle(3);
        finish_run();
    end
endmodule